// File: doc/BRIEF.md
# Byte-Bus Atomic Word Register Bridge

This block lets a peripheral with an 8-bit data bus own a bank of three 16-bit registers: a counter register and two data registers. A word moves as two byte accesses, upper byte first, through one shared 8-bit holding latch. Because of that latch, the two halves of a word always change, or are sampled, together.

An upper-byte write only parks the byte in the latch. The lower-byte write then commits the full word in a single cycle. An upper-byte read returns the live upper byte and, in the same cycle, copies the live lower byte into the latch. The lower-byte read that follows returns that copy.

The block also drives all three words to the converter core, which may load the counter register directly. A separate byte register holds one stop bit per channel.

Top module: `wordbank_bridge`

## Requirements
- R1: After reset, all three 16-bit registers, the holding latch and the read data are zero, and both stop bits are 1.
- R2: A write to an upper-byte address (0, 2 or 4) stores the byte in the holding latch and leaves all three registers unchanged.
- R3: A write to a lower-byte address (1, 3 or 5) loads the register of that pair with {latch, written byte} in one clock. The pairs are: addresses 0/1 for the counter, 2/3 for data register A, and 4/5 for data register B.
- R4: A read of an upper-byte address returns that register's live bits [15:8]. In the same clock it copies the register's live bits [7:0] into the holding latch.
- R5: A read of any lower-byte address returns the holding latch, not the live lower byte.
- R6: All three registers share the one latch, so an upper-byte access to one register followed by a lower-byte access to another one mixes their data.
- R7: Address 6 is the stop register. Bit 0 is channel 0 and bit 1 is channel 1, a 1 means stopped, and writing a 0 releases the channel. A read returns the bits in [1:0], with zeros above.
- R8: While core_load is high, the counter takes core_val at the next clock. A lower-byte bus write to address 1 in the same cycle wins over the core load.
- R9: Read data is registered: it is valid one clock after the read strobe and holds its value while no read is strobed.
- R10: Address 7 is unmapped. A read returns 0, and a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ctr_q | output | 16 | Counter register value |
| da_q | output | 16 | Data register A value |
| db_q | output | 16 | Data register B value |
| core_load | input | 1 | Core load request for the counter |
| core_val | input | 16 | Value loaded by the core |
| stop_q | output | 2 | Per-channel stop bits |

## Verification
The hardest case to reach is a counter that changes under a word read that is only half done. The core loads a new counter value between the upper-byte read and the lower-byte read, and the lower-byte read must still return the old low byte. The bench reaches this by hand: it reads address 0, pulses core_load with a fresh value, and then reads address 1. It also drives core_load and a lower-byte bus write to the counter in the same cycle, and checks that the bus value wins. Cross-register mixing through the shared latch is provoked on purpose, in both the read direction and the write direction.

// File: rtl/wordbank_bridge.sv
module wordbank_bridge #(
  parameter int DW  = 8,
  parameter int NCH = 2,
  parameter int AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [2*DW-1:0]   ctr_q,
  output logic [2*DW-1:0]   da_q,
  output logic [2*DW-1:0]   db_q,
  input  logic              core_load,
  input  logic [2*DW-1:0]   core_val,
  output logic [NCH-1:0]    stop_q
);
  localparam int NREG = 3;
  localparam int WW   = 2 * DW;
  localparam logic [AW-1:0] STOP_ADDR = AW'(2 * NREG);

  logic [WW-1:0] regs [NREG];
  logic [DW-1:0] tmp_q;
  logic [DW-1:0] rdata_q;
  logic [NCH-1:0] stop_r;
  logic [WW-1:0] live;

  wire [AW-2:0] sel     = bus_addr[AW-1:1];
  wire          is_lo   = bus_addr[0];
  wire          in_bank = bus_addr < STOP_ADDR;
  wire          wr_lo   = bus_wr && in_bank && is_lo;

  always_comb begin
    live = '0;
    for (int i = 0; i < NREG; i++)
      if (sel == (AW-1)'(i)) live = regs[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmp_q <= '0;
    end else if (bus_wr && in_bank && !is_lo) begin
      tmp_q <= bus_wdata;
    end else if (bus_rd && in_bank && !is_lo) begin
      tmp_q <= live[DW-1:0];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_lo && sel == (AW-1)'(g))
        regs[g] <= {tmp_q, bus_wdata};
      else if (g == 0 && core_load)
        regs[g] <= core_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      stop_r <= '1;
    else if (bus_wr && bus_addr == STOP_ADDR)
      stop_r <= bus_wdata[NCH-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (bus_rd) begin
      if (in_bank)
        rdata_q <= is_lo ? tmp_q : live[WW-1:DW];
      else if (bus_addr == STOP_ADDR)
        rdata_q <= DW'(stop_r);
      else
        rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign ctr_q     = regs[0];
  assign da_q      = regs[1];
  assign db_q      = regs[2];
  assign stop_q    = stop_r;
endmodule

// File: rtl/wordbank_bridge_chk.sv
module wordbank_bridge_chk #(
  parameter int DW  = 8,
  parameter int AW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [2*DW-1:0] ctr_q,
  input logic [2*DW-1:0] da_q,
  input logic [2*DW-1:0] db_q,
  input logic            core_load,
  input logic [2*DW-1:0] core_val,
  input logic [DW-1:0]   tmp_q
);
  wire bank = bus_addr < AW'(6);

  assert_hi_write_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bank && !bus_addr[0]) |=> ($stable(da_q) && $stable(db_q)));

  assert_lo_write_commits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == AW'(3)) |=> (da_q == {$past(tmp_q), $past(bus_wdata)}));

  assert_hi_read_snapshots_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == AW'(2)) |=>
      (bus_rdata == $past(da_q[2*DW-1:DW]) && tmp_q == $past(da_q[DW-1:0])));

  assert_lo_read_from_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bank && bus_addr[0]) |=> (bus_rdata == $past(tmp_q)));

  assert_core_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_load && !(bus_wr && bus_addr == AW'(1))) |=> (ctr_q == $past(core_val)));

  assert_rdata_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind wordbank_bridge wordbank_bridge_chk #(.DW(DW), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctr_q(ctr_q), .da_q(da_q), .db_q(db_q),
  .core_load(core_load), .core_val(core_val), .tmp_q(tmp_q)
);

// File: tb/wordbank_bridge_test.sv
module wordbank_bridge_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = '0;
  logic rd = 0, wr = 0, load = 0;
  logic [7:0] wdata = '0, q;
  logic [15:0] lval = '0;
  wire  [7:0] rdata;
  wire  [15:0] ctr, da, db;
  wire  [1:0] stop;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wordbank_bridge uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .ctr_q(ctr), .da_q(da), .db_q(db),
    .core_load(load), .core_val(lval), .stop_q(stop)
  );

  // {req[3:0], op(1=read), addr[2:0], data[7:0], expected[7:0]}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {4'd3,  1'b0, 3'd2, 8'h12, 8'h00},  // R3
    {4'd3,  1'b0, 3'd3, 8'h34, 8'h00},
    {4'd4,  1'b1, 3'd2, 8'h00, 8'h12},  // R4
    {4'd5,  1'b1, 3'd3, 8'h00, 8'h34},  // R5
    {4'd3,  1'b0, 3'd4, 8'hCD, 8'h00},
    {4'd3,  1'b0, 3'd5, 8'hEF, 8'h00},
    {4'd4,  1'b1, 3'd4, 8'h00, 8'hCD},
    {4'd5,  1'b1, 3'd5, 8'h00, 8'hEF},
    {4'd4,  1'b1, 3'd2, 8'h00, 8'h12},
    {4'd6,  1'b1, 3'd5, 8'h00, 8'h34},  // R6 read mix
    {4'd7,  1'b0, 3'd6, 8'h02, 8'h00},  // R7
    {4'd7,  1'b1, 3'd6, 8'h00, 8'h02},
    {4'd10, 1'b1, 3'd7, 8'h00, 8'h00},  // R10
    {4'd10, 1'b0, 3'd7, 8'hFF, 8'h00},
    {4'd10, 1'b1, 3'd6, 8'h00, 8'h02}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [7:0] r);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; r = rdata;
  endtask

  task automatic do_load(input logic [15:0] v);
    @(negedge clk); lval = v; load = 1;
    @(negedge clk); load = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ctr", ctr, 16'h0);
    check("R1 da", da, 16'h0);
    check("R1 db", db, 16'h0);
    check("R1 stop", {14'h0, stop}, 16'h3);
    check("R1 rdata", {8'h0, rdata}, 16'h0);
    do_rd(3'd1, q); check("R1 latch", {8'h0, q}, 16'h0);
    do_rd(3'd6, q); check("R7 reset read", {8'h0, q}, 16'h3);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        do_rd(VEC[i][18:16], q);
        check($sformatf("R%0d vec%0d", VEC[i][23:20], i), {8'h0, q}, {8'h0, VEC[i][7:0]});
      end else
        do_wr(VEC[i][18:16], VEC[i][15:8]);
    end
    check("R3 da word", da, 16'h1234);
    check("R3 db word", db, 16'hCDEF);
    check("R10 ctr untouched", ctr, 16'h0);
    check("R7 stop bits", {14'h0, stop}, 16'h2);

    do_wr(3'd0, 8'h55);
    check("R2 ctr held", ctr, 16'h0);
    check("R2 da held", da, 16'h1234);
    do_wr(3'd1, 8'h66);
    check("R3 ctr word", ctr, 16'h5566);

    do_wr(3'd2, 8'h77);
    do_wr(3'd5, 8'h88);
    check("R6 write mix db", db, 16'h7788);
    check("R6 write mix da", da, 16'h1234);

    do_load(16'hBEEF);
    check("R8 core load", ctr, 16'hBEEF);
    @(negedge clk); lval = 16'h1111; load = 1; addr = 3'd1; wdata = 8'h22; wr = 1;
    @(negedge clk); load = 0; wr = 0;
    check("R8 bus wins", ctr, 16'h7722);

    do_rd(3'd0, q); check("R4 ctr hi", {8'h0, q}, 16'h0077);
    do_load(16'h9999);
    check("R8 load between", ctr, 16'h9999);
    do_rd(3'd1, q); check("R5 old low byte", {8'h0, q}, 16'h0022);

    repeat (3) @(negedge clk);
    check("R9 rdata idle", {8'h0, rdata}, 16'h0022);
    do_wr(3'd6, 8'h00);
    check("R9 rdata after write", {8'h0, rdata}, 16'h0022);
    check("R7 release", {14'h0, stop}, 16'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule